// File: doc/BRIEF.md
# Drift-Compensated Nanosecond Time-of-Day Counter

This block keeps a free-running 64-bit time of day, counted in nanoseconds, for a precision time protocol endpoint. Each reference clock cycle the count moves forward by a programmed nominal period. The rate is trimmed by a 32-bit addend that is summed into a 32-bit accumulator on every cycle. Each time that sum carries out, the count gains one extra nanosecond. This gives a fractional-nanosecond frequency trim that software adjusts by rewriting the addend.

Software reaches the block through a simple word-wide register port with five registers: control (0), time low (1), time high (2), addend (3) and accumulator (4). The 64-bit time is split into two 32-bit halves, and both halves are handled coherently. A read of the low half captures the high half into a shadow register. A write of the low half is staged and only takes effect, together with the high half, when the high half is written. This lets software set or step the time without tearing.

Top module: `tod_counter`

## Requirements
- R1: After reset the control register reads 0x00000001 (source select 1, everything else clear), and time, addend and accumulator all read 0.
- R2: While control bit 2 (enable) is clear, the time count and the accumulator hold their values.
- R3: With enable set and control bit 3 (bypass) set, the time advances by exactly the period field (control bits 25:16) on every cycle, and the accumulator holds its value whatever the addend is.
- R4: With enable set and bypass clear, the accumulator adds the addend on every cycle, modulo 2^32. The time advances by the period, plus one on each cycle where that sum carries out, so N cycles from a zero accumulator add N*period + floor(N*addend/2^32).
- R5: The addend register (address 3) reads back the value written to it, and the accumulator (address 4) is readable.
- R6: A read of the time low word (address 1) returns bits 31:0 and, on the same clock edge, copies bits 63:32 into a shadow. A later read of address 2 returns that shadow, not the live high word.
- R7: A write to address 1 leaves the running time unchanged. A write to address 2 loads time = {written high word, last low word written}.
- R8: While control bit 5 (soft reset) is set, the time count and the accumulator are forced to zero and stay there, and a time load has no effect.
- R9: Control bits 25:16, 5, 3, 2 and 1:0 read back as written, and all other control bits read 0.
- R10: A time load takes priority over the advance in the same cycle, and the count advances from the loaded value on the following cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; every state change is on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe; a read of address 1 updates the high-word shadow |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational read data for rd_addr |

## Verification
The rate logic is run with a table of period/addend pairs, and the count and accumulator are compared against N*period + floor(N*addend/2^32) after N enabled cycles. The table includes an addend of zero (no carries), quarter and half scale (regular carries), all ones (a carry on every cycle but the first), the maximum period, a period of zero (where the carries alone move the time), and a bypass row with a non-zero addend that must show no carries. Directed sequences then cover a low-word rollover during a split read, a staged low write followed by a high write, a load while counting, soft reset competing with a load, and a control write of all ones.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
// tod_pkg: shared register map, control field layout and control record
// for the nanosecond time-of-day counter.
package tod_pkg;

    localparam int ADDR_W     = 3;
    localparam int CTRL_W     = 32;
    localparam int PERIOD_LSB = 16;   // period field sits at 25:16
    localparam int SRST_BIT   = 5;
    localparam int BYPASS_BIT = 3;
    localparam int ENABLE_BIT = 2;
    localparam int SRC_W      = 2;
    localparam logic [SRC_W-1:0] SRC_RESET = 2'd1;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 3'd0,
        REG_TLO    = 3'd1,
        REG_THI    = 3'd2,
        REG_ADDEND = 3'd3,
        REG_ACCUM  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [9:0]       period;
        logic             srst;
        logic             bypass;
        logic             enable;
        logic [SRC_W-1:0] src;
    } ctrl_t;

endpackage

// File: rtl/tod_ctrl_regs.sv
`timescale 1ns/1ps
// tod_ctrl_regs: holds the control record and the rate addend.
// Assumes the caller has already split the write word into a control record
// and that at most one register is written per cycle.
module tod_ctrl_regs
    import tod_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  ctrl_t             ctrl_wval,
    input  logic              addend_we,
    input  logic [WORD_W-1:0] addend_wval,
    output ctrl_t             ctrl_q,
    output logic [WORD_W-1:0] addend_q,
    output logic [CTRL_W-1:0] ctrl_word
);

    // Control record register, source select resets to its default.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q        <= '0;
            ctrl_q.src    <= SRC_RESET;
        end else if (ctrl_we) begin
            ctrl_q        <= ctrl_wval;
        end
    end

    // Addend register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addend_q <= '0;
        else if (addend_we)
            addend_q <= addend_wval;
    end

    // Reassemble the control word for reads; unused bits read zero.
    always_comb begin
        ctrl_word                                  = '0;
        ctrl_word[PERIOD_LSB +: $bits(ctrl_q.period)] = ctrl_q.period;
        ctrl_word[SRST_BIT]                        = ctrl_q.srst;
        ctrl_word[BYPASS_BIT]                      = ctrl_q.bypass;
        ctrl_word[ENABLE_BIT]                      = ctrl_q.enable;
        ctrl_word[SRC_W-1:0]                       = ctrl_q.src;
    end

endmodule

// File: rtl/tod_rate_accum.sv
`timescale 1ns/1ps
// tod_rate_accum: fractional rate accumulator. Adds the addend every cycle
// that run is high and reports the carry of that same sum combinationally.
// Assumes clr has priority over run.
module tod_rate_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [ACC_W-1:0] addend,
    output logic [ACC_W-1:0] acc_q,
    output logic             carry
);

    logic [ACC_W:0] sum;

    // Widened sum of accumulator and addend.
    always_comb sum = {1'b0, acc_q} + {1'b0, addend};

    // Carry only counts on a cycle that actually accumulates.
    always_comb carry = run & sum[ACC_W];

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            acc_q <= '0;
        else if (run)
            acc_q <= sum[ACC_W-1:0];
    end

endmodule

// File: rtl/tod_time_core.sv
`timescale 1ns/1ps
// tod_time_core: 64-bit nanosecond count with staged low-word load and a
// high-word shadow for coherent split reads.
// Priority per cycle: clear, then load, then advance.
module tod_time_core #(
    parameter int WORD_W   = 32,
    parameter int PERIOD_W = 10,
    localparam int TIME_W  = 2 * WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                step_en,
    input  logic [PERIOD_W-1:0] period,
    input  logic                carry,
    input  logic                lo_wr,
    input  logic                hi_wr,
    input  logic [WORD_W-1:0]   wdata,
    input  logic                lo_rd,
    output logic [TIME_W-1:0]   time_q,
    output logic [WORD_W-1:0]   shadow_hi
);

    logic [WORD_W-1:0] stage_lo;
    logic [TIME_W-1:0] step;

    // Increment for one cycle: nominal period plus a carry nanosecond.
    always_comb step = TIME_W'(period) + TIME_W'(carry);

    // Time count register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            time_q <= '0;
        else if (hi_wr)
            time_q <= {wdata, stage_lo};
        else if (step_en)
            time_q <= time_q + step;
    end

    // Staging register for the low half of a pending load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_lo <= '0;
        else if (lo_wr)
            stage_lo <= wdata;
    end

    // High-half shadow captured on each low-half read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_hi <= '0;
        else if (lo_rd)
            shadow_hi <= time_q[TIME_W-1:WORD_W];
    end

endmodule

// File: rtl/tod_counter.sv
`timescale 1ns/1ps
// tod_counter: drift-compensated nanosecond time-of-day counter with a
// word-wide register port. Assumes a single clock domain and single-cycle
// write and read strobes.
module tod_counter
    import tod_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int PERIOD_W = 10,
    parameter int ACC_W    = 32,
    localparam int TIME_W  = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    ctrl_t              ctrl_q;
    ctrl_t              ctrl_wval;
    logic [WORD_W-1:0]  addend_q;
    logic [CTRL_W-1:0]  ctrl_word;
    logic [ACC_W-1:0]   acc_q;
    logic               carry;
    logic [TIME_W-1:0]  time_q;
    logic [WORD_W-1:0]  shadow_hi;
    logic               ctrl_we, addend_we, lo_wr, hi_wr, lo_rd;
    logic               acc_run;

    // Write and read strobe decode.
    always_comb begin
        ctrl_we   = wr_en && (wr_addr == REG_CTRL);
        addend_we = wr_en && (wr_addr == REG_ADDEND);
        lo_wr     = wr_en && (wr_addr == REG_TLO);
        hi_wr     = wr_en && (wr_addr == REG_THI);
        lo_rd     = rd_en && (rd_addr == REG_TLO);
    end

    // Split the write word into the control record.
    always_comb begin
        ctrl_wval.period = wr_data[PERIOD_LSB +: PERIOD_W];
        ctrl_wval.srst   = wr_data[SRST_BIT];
        ctrl_wval.bypass = wr_data[BYPASS_BIT];
        ctrl_wval.enable = wr_data[ENABLE_BIT];
        ctrl_wval.src    = wr_data[SRC_W-1:0];
    end

    // The accumulator only runs when counting with compensation.
    always_comb acc_run = ctrl_q.enable && !ctrl_q.bypass && !ctrl_q.srst;

    tod_ctrl_regs #(.WORD_W(WORD_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_we     (ctrl_we),
        .ctrl_wval   (ctrl_wval),
        .addend_we   (addend_we),
        .addend_wval (wr_data),
        .ctrl_q      (ctrl_q),
        .addend_q    (addend_q),
        .ctrl_word   (ctrl_word)
    );

    tod_rate_accum #(.ACC_W(ACC_W)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ctrl_q.srst),
        .run    (acc_run),
        .addend (ACC_W'(addend_q)),
        .acc_q  (acc_q),
        .carry  (carry)
    );

    tod_time_core #(.WORD_W(WORD_W), .PERIOD_W(PERIOD_W)) u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ctrl_q.srst),
        .step_en   (ctrl_q.enable),
        .period    (ctrl_q.period),
        .carry     (carry),
        .lo_wr     (lo_wr),
        .hi_wr     (hi_wr),
        .wdata     (wr_data),
        .lo_rd     (lo_rd),
        .time_q    (time_q),
        .shadow_hi (shadow_hi)
    );

    // Read data multiplexer.
    always_comb begin
        case (rd_addr)
            REG_CTRL:   rd_data = WORD_W'(ctrl_word);
            REG_TLO:    rd_data = time_q[WORD_W-1:0];
            REG_THI:    rd_data = shadow_hi;
            REG_ADDEND: rd_data = addend_q;
            REG_ACCUM:  rd_data = WORD_W'(acc_q);
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tod_counter_chk.sv
`timescale 1ns/1ps
// tod_counter_chk: temporal properties of the time counter, bound to the top.
module tod_counter_chk #(
    parameter int WORD_W   = 32,
    parameter int PERIOD_W = 10,
    parameter int ACC_W    = 32,
    localparam int TIME_W  = 2 * WORD_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enable,
    input logic                bypass,
    input logic                srst,
    input logic [PERIOD_W-1:0] period,
    input logic                hi_wr,
    input logic                lo_wr,
    input logic                lo_rd,
    input logic [TIME_W-1:0]   time_q,
    input logic [ACC_W-1:0]    acc_q,
    input logic [WORD_W-1:0]   shadow_hi
);

    // R2: count and accumulator hold while disabled.
    a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !srst && !hi_wr) |=> ($stable(time_q) && $stable(acc_q)));

    // R3: bypass steps by exactly the period and leaves the accumulator alone.
    a_r3_bypass_step: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && bypass && !srst && !hi_wr) |=>
        ((time_q - $past(time_q)) == TIME_W'($past(period)) && $stable(acc_q)));

    // R4: compensated step is the period or the period plus one.
    a_r4_comp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !bypass && !srst && !hi_wr) |=>
        ((time_q - $past(time_q)) == TIME_W'($past(period)) ||
         (time_q - $past(time_q)) == TIME_W'($past(period)) + TIME_W'(1)));

    // R6: a low read captures the high half of that cycle.
    a_r6_shadow_capture: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rd |=> (shadow_hi == $past(time_q[TIME_W-1:WORD_W])));

    // R7: a low write alone does not disturb a stopped count.
    a_r7_lo_staged: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && !enable && !srst) |=> $stable(time_q));

    // R8: soft reset forces count and accumulator to zero.
    a_r8_srst_zero: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (time_q == '0 && acc_q == '0));

endmodule

bind tod_counter tod_counter_chk #(
    .WORD_W(WORD_W), .PERIOD_W(PERIOD_W), .ACC_W(ACC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (ctrl_q.enable),
    .bypass    (ctrl_q.bypass),
    .srst      (ctrl_q.srst),
    .period    (ctrl_q.period),
    .hi_wr     (hi_wr),
    .lo_wr     (lo_wr),
    .lo_rd     (lo_rd),
    .time_q    (time_q),
    .acc_q     (acc_q),
    .shadow_hi (shadow_hi)
);

// File: tb/sim_tod_counter.sv
`timescale 1ns/1ps
// sim_tod_counter: vector table for the rate logic, then directed tests.
module sim_tod_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [2:0] A_CTRL = 3'd0, A_TLO = 3'd1, A_THI = 3'd2,
                           A_ADD = 3'd3, A_ACC = 3'd4;

    // Vector: {period[9:0], bypass, addend[31:0], cycles[15:0]}
    localparam int NVEC = 6;
    localparam logic [58:0] VEC [NVEC] = '{
        {10'd8,    1'b1, 32'h4000_0000, 16'd12},
        {10'd8,    1'b0, 32'h4000_0000, 16'd12},
        {10'd7,    1'b0, 32'h8000_0000, 16'd5},
        {10'd1023, 1'b0, 32'hFFFF_FFFF, 16'd6},
        {10'd0,    1'b0, 32'h1000_0000, 16'd20},
        {10'd3,    1'b0, 32'h0000_0000, 16'd9}
    };

    tod_counter u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] cw(input logic [9:0] p, input bit en,
                                       input bit byp, input bit sr);
        return {6'd0, p, 10'd0, sr, 1'b0, byp, en, 2'd1};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    initial begin
        #(200_000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_chk(A_CTRL, 32'h0000_0001, "R1 ctrl");
        rd_chk(A_TLO,  32'h0, "R1 time lo");
        rd_chk(A_THI,  32'h0, "R1 time hi");
        rd_chk(A_ADD,  32'h0, "R1 addend");
        rd_chk(A_ACC,  32'h0, "R1 accum");

        // Rate vectors: R3 (bypass rows) and R4 (compensated rows)
        for (int i = 0; i < NVEC; i++) begin
            logic [9:0]  p;
            logic        byp;
            logic [31:0] ad;
            logic [15:0] n;
            logic [63:0] prod, exp_t;
            logic [31:0] exp_a;
            string tag;
            {p, byp, ad, n} = VEC[i];
            prod  = 64'(n) * 64'(ad);
            exp_t = 64'(n) * 64'(p) + (byp ? 64'd0 : (prod >> 32));
            exp_a = byp ? 32'd0 : prod[31:0];
            tag   = byp ? "R3" : "R4";
            wr(A_CTRL, cw(p, 1'b0, 1'b0, 1'b1));
            wr(A_ADD, ad);
            wr(A_CTRL, cw(p, 1'b1, byp, 1'b0));
            repeat (int'(n) - 1) @(negedge clk);
            wr(A_CTRL, cw(p, 1'b0, 1'b0, 1'b0));
            rd_chk(A_TLO, exp_t[31:0], {tag, " time lo"});
            rd_chk(A_THI, exp_t[63:32], {tag, " time hi"});
            rd_chk(A_ACC, exp_a, {tag, " accum (R5)"});
        end

        // R9: control field readback
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd_chk(A_CTRL, 32'h03FF_002F, "R9 ctrl all ones");
        wr(A_CTRL, cw(10'd0, 1'b0, 1'b0, 1'b0));
        rd_chk(A_CTRL, 32'h0000_0001, "R9 ctrl cleared");

        // R2: disabled count holds
        wr(A_TLO, 32'h55);
        wr(A_THI, 32'h66);
        repeat (10) @(negedge clk);
        rd_chk(A_TLO, 32'h55, "R2 hold lo");
        rd_chk(A_THI, 32'h66, "R2 hold hi");

        // R7: low write is staged until the high write
        wr(A_TLO, 32'h1234);
        rd_chk(A_TLO, 32'h55, "R7 lo staged");
        wr(A_THI, 32'hAB);
        rd_chk(A_TLO, 32'h1234, "R7 loaded lo");
        rd_chk(A_THI, 32'hAB, "R7 loaded hi");

        // R6: coherent split read across a low-word rollover
        wr(A_TLO, 32'hFFFF_FFF0);
        wr(A_THI, 32'h1);
        wr(A_CTRL, cw(10'd16, 1'b1, 1'b1, 1'b0));
        rd_chk(A_TLO, 32'hFFFF_FFF0, "R6 first lo");
        rd_chk(A_THI, 32'h1, "R6 shadow hi");
        rd_chk(A_TLO, 32'h10, "R6 second lo");
        rd_chk(A_THI, 32'h2, "R6 second hi");
        wr(A_CTRL, cw(10'd16, 1'b0, 1'b0, 1'b0));

        // R10: load beats advance, counting resumes from loaded value
        wr(A_CTRL, cw(10'd5, 1'b1, 1'b1, 1'b0));
        wr(A_TLO, 32'h100);
        wr(A_THI, 32'h7);
        wr(A_CTRL, cw(10'd5, 1'b0, 1'b0, 1'b0));
        rd_chk(A_TLO, 32'h105, "R10 lo");
        rd_chk(A_THI, 32'h7, "R10 hi");

        // R8: soft reset clears and blocks a load
        wr(A_ADD, 32'h1234_5678);
        wr(A_CTRL, cw(10'd5, 1'b1, 1'b0, 1'b0));
        repeat (4) @(negedge clk);
        wr(A_CTRL, cw(10'd5, 1'b1, 1'b0, 1'b1));
        repeat (3) @(negedge clk);
        wr(A_TLO, 32'h9);
        wr(A_THI, 32'h9);
        rd_chk(A_TLO, 32'h0, "R8 lo zero");
        rd_chk(A_THI, 32'h0, "R8 hi zero");
        rd_chk(A_ACC, 32'h0, "R8 accum zero");
        wr(A_CTRL, cw(10'd5, 1'b0, 1'b0, 1'b0));
        rd_chk(A_TLO, 32'h0, "R8 after release");

        // R5: addend readback
        rd_chk(A_ADD, 32'h1234_5678, "R5 addend");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule